// File: doc/BRIEF.md
# Byte-Serial Multicycle CPU Datapath

This block is the datapath of a small multicycle processor. The processor uses 32-bit instruction words over an 8-bit data path. The block holds an 8-bit program counter and an eight-entry register file whose entry zero always reads as zero. It also holds a 32-bit instruction register that fills one byte per cycle, the operand latches A and B, the ALU result latch, the memory-data latch, the operand and writeback multiplexers, and an 8-bit ALU with a zero flag.

An external sequencer drives the decoded control inputs each cycle. It receives the opcode and function fields and the ALU zero flag. Memory sits outside the block on a byte-wide address bus, write-data bus and read-data bus. Fetching an instruction takes four cycles, each writing one byte lane of the instruction register. The PC steps by one per fetched byte. Branch offsets and jump targets are built only from the low instruction bits.

Top module: `byte_serial_datapath`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears the PC, every byte of the instruction register, A, B, the ALU result latch, the memory-data latch and all register-file entries.
- R2: When ir_byte_we[k] is set at an edge, mem_rdata is loaded into instruction bits [8k+7:8k], and lanes whose enable is clear keep their value. opcode always shows instruction bits [31:26], and funct shows bits [5:0].
- R3: Instruction bits [25:21] select the register read into A, and bits [20:16] select the register read into B. On rf_we the write index is bits [20:16] when wr_sel_rd is 0 and bits [15:11] when it is 1. Only the low 3 bits of each 5-bit field are used, and register 0 always reads 00h, even after it has been written.
- R4: A, B, the ALU result latch and the memory-data latch load at every clock edge out of reset. mem_wdata always shows B.
- R5: alu_op selects one function. 000 gives AND, 001 gives OR, 010 gives add modulo 256, and 110 gives subtract modulo 256. 111 gives 1 when the first operand is less than the second as signed 8-bit values and 0 otherwise. All other codes give 00h.
- R6: alu_zero is 1 exactly when the current ALU result is 00h.
- R7: The first ALU operand is the PC when opa_sel is 0 and A when it is 1. The second operand depends on opb_sel: 00 gives B, 01 gives the constant 1, 10 gives instruction bits [7:0], and 11 gives instruction bits [5:0] followed by two zero bits.
- R8: The next-PC value depends on pc_src: 00 gives the live ALU result, 01 gives the ALU result latch, 10 gives instruction bits [5:0] followed by two zero bits, and 11 gives the current PC.
- R9: The PC loads the next-PC value at an edge when pc_we is 1, or when pc_we_zero is 1 and alu_zero is 1. Otherwise the PC holds.
- R10: mem_addr is the PC when addr_from_alu is 0 and the ALU result latch when it is 1.
- R11: The register write data is the ALU result latch when wb_from_mem is 0 and the memory-data latch when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_byte_we | input | 4 | Per-lane load enables of the instruction register |
| rf_we | input | 1 | Register-file write enable |
| wr_sel_rd | input | 1 | Write index from bits [15:11] (1) or [20:16] (0) |
| wb_from_mem | input | 1 | Write data from memory-data latch (1) or ALU result latch (0) |
| addr_from_alu | input | 1 | Memory address from ALU result latch (1) or PC (0) |
| opa_sel | input | 1 | First ALU operand: A (1) or PC (0) |
| opb_sel | input | 2 | Second ALU operand select |
| pc_src | input | 2 | Next-PC select |
| pc_we | input | 1 | Unconditional PC load |
| pc_we_zero | input | 1 | PC load qualified by the zero flag |
| alu_op | input | 3 | ALU function code |
| mem_rdata | input | 8 | Byte read from memory |
| mem_addr | output | 8 | Memory byte address |
| mem_wdata | output | 8 | Byte for memory writes (B) |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| alu_zero | output | 1 | ALU result equals zero |

## Verification
Some properties are checked on every cycle. Register 0 reads zero on both read ports, and a write lands in the selected entry. Idle instruction lanes hold and enabled lanes capture the read byte. The memory-data latch follows the read bus, the PC holds unless one of its load conditions is true, a jump loads the shifted low instruction bits, and set-less-than yields a single bit. Only the bench's scenarios can show the rest: the arithmetic values across a sweep of operand pairs, the operand and next-PC encodings, and register writeback through each index and data source. They also cover branch taken versus not taken, and reset in mid-run clearing what software can observe.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   localparam logic [1:0] OPB_REG  = 2'b00;
   localparam logic [1:0] OPB_ONE  = 2'b01;
   localparam logic [1:0] OPB_IMM  = 2'b10;
   localparam logic [1:0] OPB_IMM4 = 2'b11;

   localparam logic [1:0] PCS_ALU    = 2'b00;
   localparam logic [1:0] PCS_ALUOUT = 2'b01;
   localparam logic [1:0] PCS_JUMP   = 2'b10;
   localparam logic [1:0] PCS_HOLD   = 2'b11;

   localparam int INSTR_W = 32;
   localparam int FIELD_W = 5;
   localparam int OPC_LSB = 26;
   localparam int OPC_W   = 6;
   localparam int FUN_W   = 6;
   localparam int RS_LSB  = 21;
   localparam int RT_LSB  = 16;
   localparam int RD_LSB  = 11;

endpackage

// File: rtl/bsd_alu.sv
module bsd_alu
   import bsd_pkg::*;
#(
   parameter int W          = 8,
   parameter bit SLT_SIGNED = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [2:0]   op_i,
   output logic [W-1:0] y_o,
   output logic         zero_o
);

   generate
      if (W < 2) begin : g_bad_w
         $error("bsd_alu: W must be at least 2");
      end
   endgenerate

   logic lt;

   generate
      if (SLT_SIGNED) begin : g_slt_signed
         assign lt = $signed(a_i) < $signed(b_i);
      end else begin : g_slt_unsigned
         assign lt = a_i < b_i;
      end
   endgenerate

   always_comb begin
      case (op_i)
         ALU_AND: y_o = a_i & b_i;
         ALU_OR:  y_o = a_i | b_i;
         ALU_ADD: y_o = a_i + b_i;
         ALU_SUB: y_o = a_i - b_i;
         ALU_SLT: y_o = {{(W-1){1'b0}}, lt};
         default: y_o = '0;
      endcase
   end

   assign zero_o = (y_o == '0);

endmodule

// File: rtl/bsd_regfile.sv
module bsd_regfile #(
   parameter int W     = 8,
   parameter int NREG  = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] raddr_a,
   input  logic [IDX_W-1:0] raddr_b,
   output logic [W-1:0]     rdata_a,
   output logic [W-1:0]     rdata_b
);

   generate
      if ((1 << IDX_W) != NREG) begin : g_bad_depth
         $error("bsd_regfile: NREG must equal 2**IDX_W");
      end
   endgenerate

   logic [W-1:0] entry [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_entry
      if (i == 0) begin : g_zero
         assign entry[i] = '0;
      end else begin : g_store
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (we && (waddr == IDX_W'(i)))
               q <= wdata;
         end
         assign entry[i] = q;
      end
   end

   assign rdata_a = entry[raddr_a];
   assign rdata_b = entry[raddr_b];

   // R3: entry zero never returns anything but zero
   a_r3_zero_port_a: assert property (@(posedge clk) disable iff (rst)
      (raddr_a == '0) |-> (rdata_a == '0));
   a_r3_zero_port_b: assert property (@(posedge clk) disable iff (rst)
      (raddr_b == '0) |-> (rdata_b == '0));
   // R3: a write to a nonzero index is visible on the next cycle
   a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
      (we && (waddr != '0)) |=> (entry[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/bsd_instr_reg.sv
module bsd_instr_reg #(
   parameter int W     = 8,
   parameter int LANES = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [LANES-1:0]   lane_we,
   input  logic [W-1:0]       din,
   output logic [LANES*W-1:0] ir_o
);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("bsd_instr_reg: LANES must be at least 1");
      end
   endgenerate

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (lane_we[k])
            q <= din;
      end
      assign ir_o[k*W +: W] = q;

      // R2: an enabled lane captures the read byte
      a_r2_lane_load: assert property (@(posedge clk) disable iff (rst)
         lane_we[k] |=> (ir_o[k*W +: W] == $past(din)));
   end

   // R2: with no lane enabled the whole word holds
   a_r2_word_hold: assert property (@(posedge clk) disable iff (rst)
      (lane_we == '0) |=> $stable(ir_o));

endmodule

// File: rtl/byte_serial_datapath.sv
module byte_serial_datapath
   import bsd_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int NREG         = 8,
   parameter bit SLT_SIGNED   = 1'b1,
   localparam int IR_LANES    = INSTR_W / DATA_W,
   localparam int IDX_W       = $clog2(NREG)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [IR_LANES-1:0] ir_byte_we,
   input  logic                rf_we,
   input  logic                wr_sel_rd,
   input  logic                wb_from_mem,
   input  logic                addr_from_alu,
   input  logic                opa_sel,
   input  logic [1:0]          opb_sel,
   input  logic [1:0]          pc_src,
   input  logic                pc_we,
   input  logic                pc_we_zero,
   input  logic [2:0]          alu_op,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic [DATA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic [OPC_W-1:0]    opcode,
   output logic [FUN_W-1:0]    funct,
   output logic                alu_zero
);

   generate
      if ((INSTR_W % DATA_W) != 0) begin : g_bad_lane_split
         $error("byte_serial_datapath: DATA_W must divide the instruction width");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("byte_serial_datapath: DATA_W must be at least 8");
      end
      if (IDX_W > FIELD_W || NREG < 2) begin : g_bad_regs
         $error("byte_serial_datapath: NREG out of range");
      end
   endgenerate

   logic [INSTR_W-1:0] ir;
   logic [DATA_W-1:0]  pc_q, a_q, b_q, aluout_q, mdr_q;
   logic [DATA_W-1:0]  rd_a, rd_b, wdata;
   logic [DATA_W-1:0]  opa, opb, alu_y, pc_next, low_x4;
   logic [IDX_W-1:0]   rs_idx, rt_idx, rd_idx, w_idx;
   logic               pc_en;
   logic               unused_ir_bits;

   bsd_instr_reg #(.W(DATA_W), .LANES(IR_LANES)) u_ir (
      .clk     (clk),
      .rst     (rst),
      .lane_we (ir_byte_we),
      .din     (mem_rdata),
      .ir_o    (ir)
   );

   assign opcode = ir[OPC_LSB +: OPC_W];
   assign funct  = ir[FUN_W-1:0];
   assign rs_idx = ir[RS_LSB +: IDX_W];
   assign rt_idx = ir[RT_LSB +: IDX_W];
   assign rd_idx = ir[RD_LSB +: IDX_W];
   assign w_idx  = wr_sel_rd ? rd_idx : rt_idx;
   assign wdata  = wb_from_mem ? mdr_q : aluout_q;
   assign low_x4 = {ir[DATA_W-3:0], 2'b00};
   assign unused_ir_bits = ^ir;

   bsd_regfile #(.W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .we      (rf_we),
      .waddr   (w_idx),
      .wdata   (wdata),
      .raddr_a (rs_idx),
      .raddr_b (rt_idx),
      .rdata_a (rd_a),
      .rdata_b (rd_b)
   );

   assign opa = opa_sel ? a_q : pc_q;

   always_comb begin
      case (opb_sel)
         OPB_REG: opb = b_q;
         OPB_ONE: opb = DATA_W'(1);
         OPB_IMM: opb = ir[DATA_W-1:0];
         default: opb = low_x4;
      endcase
   end

   bsd_alu #(.W(DATA_W), .SLT_SIGNED(SLT_SIGNED)) u_alu (
      .a_i    (opa),
      .b_i    (opb),
      .op_i   (alu_op),
      .y_o    (alu_y),
      .zero_o (alu_zero)
   );

   always_comb begin
      case (pc_src)
         PCS_ALU:    pc_next = alu_y;
         PCS_ALUOUT: pc_next = aluout_q;
         PCS_JUMP:   pc_next = low_x4;
         default:    pc_next = pc_q;
      endcase
   end

   assign pc_en = pc_we | (pc_we_zero & alu_zero);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q     <= '0;
         a_q      <= '0;
         b_q      <= '0;
         aluout_q <= '0;
         mdr_q    <= '0;
      end else begin
         a_q      <= rd_a;
         b_q      <= rd_b;
         aluout_q <= alu_y;
         mdr_q    <= mem_rdata;
         if (pc_en)
            pc_q <= pc_next;
      end
   end

   assign mem_addr  = addr_from_alu ? aluout_q : pc_q;
   assign mem_wdata = b_q;

   // R9: without a load condition the PC keeps its value
   a_r9_pc_hold: assert property (@(posedge clk) disable iff (rst)
      !(pc_we || (pc_we_zero && alu_zero)) |=> $stable(pc_q));
   // R8: a jump lands on the low instruction bits times four
   a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
      (pc_we && (pc_src == PCS_JUMP)) |=> (pc_q == {$past(ir[DATA_W-3:0]), 2'b00}));
   // R4: the memory-data latch follows the read bus each cycle
   a_r4_mdr_follows: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (mdr_q == $past(mem_rdata)));
   // R5: set-less-than yields a single bit
   a_r5_slt_bit: assert property (@(posedge clk) disable iff (rst)
      (alu_op == ALU_SLT) |-> (alu_y[DATA_W-1:1] == '0));

endmodule

// File: tb/byte_serial_datapath_tb_top.sv
`timescale 1ns/1ps
module byte_serial_datapath_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] ir_byte_we;
   logic       rf_we, wr_sel_rd, wb_from_mem, addr_from_alu, opa_sel;
   logic [1:0] opb_sel, pc_src;
   logic       pc_we, pc_we_zero;
   logic [2:0] alu_op;
   logic [7:0] mem_rdata, mem_addr, mem_wdata;
   logic [5:0] opcode, funct;
   logic       alu_zero;

   logic [7:0] mem [0:255];
   int         n_chk = 0;
   int         n_err = 0;
   bit         finished = 1'b0;
   logic [7:0] exp_pc;

   always #10 clk = ~clk;

   assign mem_rdata = mem[mem_addr];

   byte_serial_datapath dut_i (
      .clk(clk), .rst(rst), .ir_byte_we(ir_byte_we), .rf_we(rf_we),
      .wr_sel_rd(wr_sel_rd), .wb_from_mem(wb_from_mem),
      .addr_from_alu(addr_from_alu), .opa_sel(opa_sel), .opb_sel(opb_sel),
      .pc_src(pc_src), .pc_we(pc_we), .pc_we_zero(pc_we_zero), .alu_op(alu_op),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .opcode(opcode), .funct(funct), .alu_zero(alu_zero)
   );

   function automatic logic [7:0] alu_ref(logic [2:0] op, logic [7:0] a, logic [7:0] b);
      case (op)
         3'b000:  return a & b;
         3'b001:  return a | b;
         3'b010:  return a + b;
         3'b110:  return a - b;
         3'b111:  return ($signed(a) < $signed(b)) ? 8'd1 : 8'd0;
         default: return 8'd0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle;
      ir_byte_we = '0; rf_we = 0; wr_sel_rd = 0; wb_from_mem = 0;
      addr_from_alu = 0; opa_sel = 0; opb_sel = 2'b00; pc_src = 2'b00;
      pc_we = 0; pc_we_zero = 0; alu_op = 3'b000;
   endtask

   // fill the instruction register at the current PC without moving it
   task automatic load_ir(input logic [31:0] w);
      for (int k = 3; k >= 0; k--) begin
         idle();
         mem[exp_pc] = w[k*8 +: 8];
         ir_byte_we = 4'(1 << k);
         tick();
      end
      idle();
   endtask

   task automatic set_reg(input int r, input logic [7:0] v);
      load_ir({6'd0, 5'd0, 5'(r), 16'd0});
      mem[exp_pc] = v;
      tick();
      rf_we = 1; wb_from_mem = 1; wr_sel_rd = 0;
      tick();
      idle();
   endtask

   task automatic get_reg(input int f, output logic [7:0] v);
      load_ir({6'd0, 5'(f), 5'(f), 16'd0});
      tick();
      v = mem_wdata;
   endtask

   task automatic alu_pair(input logic [7:0] x, input logic [7:0] y);
      logic [7:0] e;
      set_reg(1, x);
      load_ir({6'd0, 5'd1, 5'd1, 8'd0, y});
      tick();
      for (int j = 0; j < 8; j++) begin
         idle();
         opa_sel = 1; opb_sel = 2'b10; alu_op = 3'(j); addr_from_alu = 1;
         e = alu_ref(3'(j), x, y);
         #1;
         chk("R6 zero flag", {31'd0, alu_zero}, {31'd0, (e == 8'd0)});
         tick();
         chk("R5 ALU result via R10 address", {24'd0, mem_addr}, {24'd0, e});
      end
      idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] tgt;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      idle();
      rst = 1;
      exp_pc = 8'd0;
      repeat (3) tick();
      rst = 0;
      #1;
      // R1 reset state
      chk("R1 pc after reset", {24'd0, mem_addr}, 32'd0);
      chk("R1 B after reset", {24'd0, mem_wdata}, 32'd0);
      chk("R1 opcode after reset", {26'd0, opcode}, 32'd0);
      chk("R1 funct after reset", {26'd0, funct}, 32'd0);
      chk("R1 zero after reset", {31'd0, alu_zero}, 32'd1);

      // R2 and R8: fetch four bytes, PC steps by one through the live ALU result
      begin
         logic [31:0] w;
         w = 32'hA5C3_9E7B;
         for (int k = 3; k >= 0; k--) begin
            idle();
            mem[exp_pc] = w[k*8 +: 8];
            ir_byte_we = 4'(1 << k);
            opa_sel = 0; opb_sel = 2'b01; alu_op = 3'b010; pc_src = 2'b00; pc_we = 1;
            tick();
            exp_pc = exp_pc + 8'd1;
            chk("R8 fetch pc increment", {24'd0, mem_addr}, {24'd0, exp_pc});
         end
         idle();
         chk("R2 opcode after fetch", {26'd0, opcode}, {26'd0, w[31:26]});
         chk("R2 funct after fetch", {26'd0, funct}, {26'd0, w[5:0]});
         mem[exp_pc] = 8'hFF;
         ir_byte_we = 4'b0001;
         tick();
         idle();
         chk("R2 lane 0 loads alone", {26'd0, funct}, 32'h3F);
         chk("R2 lane 3 untouched", {26'd0, opcode}, {26'd0, w[31:26]});
         chk("R9 pc held without enables", {24'd0, mem_addr}, {24'd0, exp_pc});
      end

      // R3 and R11: register file through the memory-data path
      for (int r = 0; r < 8; r++) set_reg(r, 8'(8'h11 * r + 8'h0E));
      for (int r = 0; r < 8; r++) begin
         get_reg(r, v);
         chk("R3 register readback", {24'd0, v}, (r == 0) ? 32'd0 : {24'd0, 8'(8'h11 * r + 8'h0E)});
      end
      for (int r = 1; r < 4; r++) begin
         get_reg(r + 8 * r, v);
         chk("R3 upper field bits ignored", {24'd0, v}, {24'd0, 8'(8'h11 * r + 8'h0E)});
      end

      // R3, R4, R11: writeback of the ALU result latch into the rd-selected entry
      set_reg(1, 8'h37);
      set_reg(2, 8'h55);
      load_ir({6'd0, 5'd1, 5'd2, 5'd3, 11'd0});
      tick();
      chk("R4 mem_wdata shows B", {24'd0, mem_wdata}, 32'h55);
      opa_sel = 1; opb_sel = 2'b00; alu_op = 3'b010;
      tick();
      rf_we = 1; wr_sel_rd = 1; wb_from_mem = 0;
      tick();
      idle();
      get_reg(3, v);
      chk("R11 rd write from ALU result latch", {24'd0, v}, 32'h8C);
      get_reg(2, v);
      chk("R3 rt entry untouched by rd write", {24'd0, v}, 32'h55);

      // R7: constant one and shifted immediate with A
      set_reg(6, 8'h40);
      load_ir({6'd0, 5'd6, 5'd6, 8'd0, 8'hC9});
      tick();
      opa_sel = 1; opb_sel = 2'b01; alu_op = 3'b010; addr_from_alu = 1;
      tick();
      chk("R7 operand B constant one", {24'd0, mem_addr}, 32'h41);
      opb_sel = 2'b11;
      tick();
      chk("R7 operand B immediate times four", {24'd0, mem_addr}, 32'h64);
      opb_sel = 2'b00;
      tick();
      chk("R7 operand B register", {24'd0, mem_addr}, 32'h80);
      idle();

      // R9: branch taken when equal
      set_reg(4, 8'h20);
      set_reg(5, 8'h20);
      load_ir({6'd4, 5'd4, 5'd5, 8'd0, 8'd6});
      tgt = exp_pc + 8'd24;
      opa_sel = 0; opb_sel = 2'b11; alu_op = 3'b010;
      tick();
      idle();
      opa_sel = 1; opb_sel = 2'b00; alu_op = 3'b110; pc_src = 2'b01; pc_we_zero = 1;
      #1;
      chk("R6 zero on equal operands", {31'd0, alu_zero}, 32'd1);
      tick();
      idle();
      exp_pc = tgt;
      chk("R9 branch taken", {24'd0, mem_addr}, {24'd0, exp_pc});

      // R9: branch not taken when different
      set_reg(5, 8'h21);
      load_ir({6'd4, 5'd4, 5'd5, 8'd0, 8'd6});
      opa_sel = 0; opb_sel = 2'b11; alu_op = 3'b010;
      tick();
      idle();
      opa_sel = 1; opb_sel = 2'b00; alu_op = 3'b110; pc_src = 2'b01; pc_we_zero = 1;
      #1;
      chk("R6 nonzero on different operands", {31'd0, alu_zero}, 32'd0);
      tick();
      idle();
      chk("R9 branch not taken", {24'd0, mem_addr}, {24'd0, exp_pc});

      // R8: jump target and hold code
      load_ir({6'd2, 20'd0, 6'h2D});
      pc_src = 2'b10; pc_we = 1;
      tick();
      idle();
      exp_pc = 8'hB4;
      chk("R8 jump target", {24'd0, mem_addr}, 32'hB4);
      pc_src = 2'b11; pc_we = 1; opa_sel = 0; opb_sel = 2'b01; alu_op = 3'b010;
      tick();
      idle();
      chk("R8 hold code keeps pc", {24'd0, mem_addr}, 32'hB4);

      // R5, R6, R10: operand sweep through the immediate path
      alu_pair(8'h00, 8'h00);
      alu_pair(8'hFF, 8'h01);
      alu_pair(8'h80, 8'h7F);
      alu_pair(8'h7F, 8'h80);
      alu_pair(8'h5A, 8'h5A);
      for (int xi = 0; xi < 48; xi++) begin
         for (int yi = 0; yi < 24; yi++) begin
            alu_pair(8'(xi * 37 + 3), 8'(yi * 53 + 1));
         end
      end

      // R1: reset mid-run
      rst = 1;
      tick();
      rst = 0;
      exp_pc = 8'd0;
      #1;
      chk("R1 pc after mid reset", {24'd0, mem_addr}, 32'd0);
      chk("R1 ir after mid reset", {26'd0, opcode}, 32'd0);
      chk("R1 B after mid reset", {24'd0, mem_wdata}, 32'd0);
      get_reg(4, v);
      chk("R1 register cleared", {24'd0, v}, 32'd0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule